// File: doc/BRIEF.md
# Pin Identity Pulse-Train Encoder

The block drives a set of output pins. Each pin repeats a short serial code that says which package ball it is wired to, so a person watching any one pin with an LED or a probe can read off the ball without other equipment. Every lane carries a fixed ball identity, given by two elaboration parameters: a row index (letter A counts as 1, B as 2, and so on) and a column number. A lane repeats one frame forever. The frame has three parts: an alternating start marker, a burst whose pulse count is the row index, and a burst whose pulse count is the column number. Low gaps separate the parts.

One bit-rate strobe, produced by a clock divider that can be changed at run time, paces all lanes. With a slow setting the pattern can be read on an LED. All lanes start their first frame on the same strobe after reset. The external reset is asynchronous and active low. Inside the block it is released in step with the clock.

Top module: `pinid_encoder`

## Requirements
- R1: While `rst_n` is low, and until the first bit boundary after its release, every bit of `pins_o` is 0. The release passes through a two-stage synchronizer, so the first bit boundary can come no earlier than the third rising clock edge after `rst_n` goes high.
- R2: A bit lasts `div_val`+1 clock cycles. A setting of 0 starts a new bit on every clock.
- R3: A new `div_val` takes effect at once. When the cycles already counted in the current bit reach or exceed the new setting, the bit ends at the next clock edge. Otherwise the bit ends once the count reaches the new setting.
- R4: The first bit boundary after reset loads a 1 on every active lane at the same time, so all active lanes start their frames aligned.
- R5: Every frame begins with 14 bits that alternate 1,0,1,0 and so on, starting with 1.
- R6: Four 0 bits follow the start marker. Then comes the row burst: R pulses, where R is the lane's row index and each pulse is the three bits 1,0,0.
- R7: Four 0 bits follow the row burst. Then comes the column burst: C pulses of 1,0,0, where C is the lane's column number.
- R8: Three 0 bits close the frame, and the next frame follows at once. A frame is 25+3(R+C) bits long.
- R9: A lane whose row index or column number is 0 keeps its pin at 0 at all times.
- R10: No lane ever carries a 1 in two consecutive bits.
- R11: Pins change only at bit boundaries. Between boundaries they hold their value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with the clock inside the block |
| div_val | input | DIV_W | Bit length minus one, in clock cycles |
| pins_o | output | N_LANES | Registered identity codes, one bit per lane |

## Verification
The case that is hardest to reach from the ports is shrinking the divider while a bit is already past the new length. This only happens when the new setting arrives in a cycle where the count inside the current bit is larger than that setting. The stimulus keeps its own count of cycles since the last bit boundary. It waits until four cycles of a six-cycle bit have passed, then writes a divider of one, so the next edge must start a bit. A second hard case is a reset that lands in the middle of a long frame. The stimulus issues it while the lane with the 31/31 identity is partway through its column burst, then checks that every active lane begins again at the first marker bit.

// File: rtl/pinid_pkg.sv
package pinid_pkg;

  localparam int unsigned ID_W       = 5;
  localparam int unsigned MARK_BITS  = 14;
  localparam int unsigned GAP_BITS   = 4;
  localparam int unsigned TAIL_BITS  = 3;
  localparam int unsigned PULSE_BITS = 3;
  localparam int unsigned SPAN_W     = $clog2(MARK_BITS);
  localparam int unsigned SUB_W      = $clog2(PULSE_BITS);

  typedef enum logic [2:0] {
    PH_MARK,
    PH_GAP_ROW,
    PH_ROW,
    PH_GAP_COL,
    PH_COL,
    PH_TAIL
  } phase_e;

  function automatic int unsigned frame_bits(input int unsigned row_id,
                                             input int unsigned col_id);
    return MARK_BITS + 2 * GAP_BITS + TAIL_BITS + PULSE_BITS * (row_id + col_id);
  endfunction

endpackage

// File: rtl/pinid_rst_sync.sv
module pinid_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_o = stage2_q;

endmodule

// File: rtl/pinid_bit_divider.sv
module pinid_bit_divider #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;
  logic             tick;

  // A count at or past the limit ends the bit; this also covers a limit
  // lowered below the running count.
  always_comb begin
    tick  = (cnt_q >= div_val);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign tick_o = tick;

endmodule

// File: rtl/pinid_lane_seq.sv
module pinid_lane_seq
  import pinid_pkg::*;
#(
  parameter int unsigned ROW_ID = 1,
  parameter int unsigned COL_ID = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic pin_o
);

  localparam logic [SPAN_W-1:0] MARK_LAST  = SPAN_W'(MARK_BITS - 1);
  localparam logic [SPAN_W-1:0] GAP_LAST   = SPAN_W'(GAP_BITS - 1);
  localparam logic [SPAN_W-1:0] TAIL_LAST  = SPAN_W'(TAIL_BITS - 1);
  localparam logic [SUB_W-1:0]  SUB_LAST   = SUB_W'(PULSE_BITS - 1);
  localparam logic [ID_W-1:0]   ROW_LAST   = ID_W'(ROW_ID - 1);
  localparam logic [ID_W-1:0]   COL_LAST   = ID_W'(COL_ID - 1);

  phase_e            phase_q, phase_d;
  logic [SPAN_W-1:0] span_q,  span_d;
  logic [SUB_W-1:0]  sub_q,   sub_d;
  logic [ID_W-1:0]   pulse_q, pulse_d;
  logic              pin_q;
  logic              bit_now;
  logic [ID_W-1:0]   burst_last;
  phase_e            burst_exit;

  always_comb begin
    phase_d    = phase_q;
    span_d     = span_q;
    sub_d      = sub_q;
    pulse_d    = pulse_q;
    bit_now    = 1'b0;
    burst_last = (phase_q == PH_ROW) ? ROW_LAST : COL_LAST;
    burst_exit = (phase_q == PH_ROW) ? PH_GAP_COL : PH_TAIL;

    unique case (phase_q)
      PH_MARK: begin
        bit_now = ~span_q[0];
        if (span_q == MARK_LAST) begin
          phase_d = PH_GAP_ROW;
          span_d  = '0;
        end else begin
          span_d  = span_q + 1'b1;
        end
      end
      PH_GAP_ROW, PH_GAP_COL: begin
        if (span_q == GAP_LAST) begin
          phase_d = (phase_q == PH_GAP_ROW) ? PH_ROW : PH_COL;
          span_d  = '0;
          sub_d   = '0;
          pulse_d = '0;
        end else begin
          span_d  = span_q + 1'b1;
        end
      end
      PH_ROW, PH_COL: begin
        bit_now = (sub_q == '0);
        if (sub_q == SUB_LAST) begin
          sub_d = '0;
          if (pulse_q == burst_last) begin
            phase_d = burst_exit;
            pulse_d = '0;
            span_d  = '0;
          end else begin
            pulse_d = pulse_q + 1'b1;
          end
        end else begin
          sub_d = sub_q + 1'b1;
        end
      end
      PH_TAIL: begin
        if (span_q == TAIL_LAST) begin
          phase_d = PH_MARK;
          span_d  = '0;
        end else begin
          span_d  = span_q + 1'b1;
        end
      end
      default: begin
        phase_d = PH_MARK;
        span_d  = '0;
        sub_d   = '0;
        pulse_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_MARK;
      span_q  <= '0;
      sub_q   <= '0;
      pulse_q <= '0;
      pin_q   <= 1'b0;
    end else if (tick) begin
      phase_q <= phase_d;
      span_q  <= span_d;
      sub_q   <= sub_d;
      pulse_q <= pulse_d;
      pin_q   <= bit_now;
    end
  end

  assign pin_o = pin_q;

endmodule

// File: rtl/pinid_encoder.sv
module pinid_encoder
  import pinid_pkg::*;
#(
  parameter int unsigned                     N_LANES = 8,
  parameter int unsigned                     DIV_W   = 16,
  parameter logic [N_LANES*pinid_pkg::ID_W-1:0] ROW_IDS =
    {5'd4, 5'd12, 5'd7, 5'd0, 5'd31, 5'd3, 5'd2, 5'd1},
  parameter logic [N_LANES*pinid_pkg::ID_W-1:0] COL_IDS =
    {5'd16, 5'd3, 5'd0, 5'd7, 5'd31, 5'd4, 5'd5, 5'd1}
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DIV_W-1:0]   div_val,
  output logic [N_LANES-1:0] pins_o
);

  function automatic logic [N_LANES-1:0] active_lanes();
    logic [N_LANES-1:0] m;
    m = '0;
    for (int i = 0; i < N_LANES; i++) begin
      m[i] = (ROW_IDS[i*ID_W +: ID_W] != '0) && (COL_IDS[i*ID_W +: ID_W] != '0);
    end
    return m;
  endfunction

  localparam logic [N_LANES-1:0] LANE_ACTIVE = active_lanes();

  logic rst_sync_n;
  logic bit_tick;

  pinid_rst_sync u_rst_sync (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  pinid_bit_divider #(
    .DIV_W (DIV_W)
  ) u_divider (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .div_val (div_val),
    .tick_o  (bit_tick)
  );

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    localparam int unsigned ROW_G = int'(ROW_IDS[g*ID_W +: ID_W]);
    localparam int unsigned COL_G = int'(COL_IDS[g*ID_W +: ID_W]);
    if (ROW_G == 0 || COL_G == 0) begin : g_idle
      assign pins_o[g] = 1'b0;
    end else begin : g_seq
      pinid_lane_seq #(
        .ROW_ID (ROW_G),
        .COL_ID (COL_G)
      ) u_seq (
        .clk   (clk),
        .rst_n (rst_sync_n),
        .tick  (bit_tick),
        .pin_o (pins_o[g])
      );
    end
  end

endmodule

// File: rtl/pinid_encoder_chk.sv
module pinid_encoder_chk #(
  parameter int unsigned         N_LANES     = 8,
  parameter int unsigned         DIV_W       = 16,
  parameter logic [N_LANES-1:0]  ACTIVE_MASK = '1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [DIV_W-1:0]   div_val,
  input logic               tick,
  input logic [N_LANES-1:0] pins
);

  logic [DIV_W:0]       since_q;
  logic                 seen_q;
  logic [N_LANES-1:0]   last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= '0;
      seen_q  <= 1'b0;
      last_q  <= '0;
    end else begin
      if (tick) begin
        since_q <= '0;
        seen_q  <= 1'b1;
        last_q  <= pins;
      end else if (since_q != '1) begin
        since_q <= since_q + 1'b1;
      end
    end
  end

  // R1: outputs stay low while the block is held in reset
  a_r1_low_in_reset: assert property (@(posedge clk)
    !rst_n |-> (pins == '0));

  // R2: a bit never outlasts the divider setting
  a_r2_tick_due: assert property (@(posedge clk) disable iff (!rst_n)
    (since_q >= {1'b0, div_val}) |-> tick);

  // R4: the first boundary loads a 1 on every active lane
  a_r4_aligned_start: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !seen_q) |=> (pins == ACTIVE_MASK));

  // R10: no lane holds a 1 across two consecutive bits
  a_r10_no_double_high: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> ((last_q & pins) == '0));

  // R11: pins move only on bit boundaries
  a_r11_hold_off_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(pins));

endmodule

bind pinid_encoder pinid_encoder_chk #(
  .N_LANES     (N_LANES),
  .DIV_W       (DIV_W),
  .ACTIVE_MASK (LANE_ACTIVE)
) u_pinid_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .div_val (div_val),
  .tick    (bit_tick),
  .pins    (pins_o)
);

// File: tb/pinid_encoder_tb_top.sv
module pinid_encoder_tb_top;

  localparam int N  = 8;
  localparam int DW = 16;
  localparam logic [N*5-1:0] ROWS = {5'd4, 5'd12, 5'd7, 5'd0, 5'd31, 5'd3, 5'd2, 5'd1};
  localparam logic [N*5-1:0] COLS = {5'd16, 5'd3, 5'd0, 5'd7, 5'd31, 5'd4, 5'd5, 5'd1};

  logic          clk;
  logic          rst_n;
  logic [DW-1:0] div_val;
  logic [N-1:0]  pins;

  int checks;
  int fails;
  bit finished;

  logic [N-1:0]   exp_q[$];
  logic [N*8-1:0] pos_q[$];
  int             lane_pos[N];
  logic [N-1:0]   cur_exp;
  logic [N*8-1:0] cur_pos;
  logic [N-1:0]   prev_pins;
  logic [N-1:0]   act_mask;
  int             sync_cnt;
  int             cnt_m;
  bit             tick_m;
  bit             seen_tick;
  string          ctx;

  pinid_encoder #(
    .N_LANES (N),
    .DIV_W   (DW),
    .ROW_IDS (ROWS),
    .COL_IDS (COLS)
  ) dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .div_val (div_val),
    .pins_o  (pins)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int row_of(int i);
    return int'(ROWS[i*5 +: 5]);
  endfunction

  function automatic int col_of(int i);
    return int'(COLS[i*5 +: 5]);
  endfunction

  function automatic int flen(int i);
    return 25 + 3 * (row_of(i) + col_of(i));
  endfunction

  function automatic logic bit_at(int i, int pos);
    int p;
    int r;
    int c;
    r = row_of(i);
    c = col_of(i);
    if (pos < 14) return (pos % 2) == 0;
    p = pos - 14;
    if (p < 4) return 1'b0;
    p = p - 4;
    if (p < 3 * r) return (p % 3) == 0;
    p = p - 3 * r;
    if (p < 4) return 1'b0;
    p = p - 4;
    if (p < 3 * c) return (p % 3) == 0;
    return 1'b0;
  endfunction

  function automatic string tag_of(int i, int pos);
    int r;
    int c;
    r = row_of(i);
    c = col_of(i);
    if (r == 0 || c == 0) return "R9";
    if (pos < 14) return "R5";
    if (pos < 18 + 3 * r) return "R6";
    if (pos < 22 + 3 * r + 3 * c) return "R7";
    return "R8";
  endfunction

  task automatic check(bit ok, string tag, logic [N-1:0] got, logic [N-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s [%s] pins got=%b exp=%b at %0t", tag, ctx, got, exp, $time);
    end
  endtask

  // driver: queues the expected pin vector for each coming bit
  task automatic push_bits(int n);
    for (int k = 0; k < n; k++) begin
      logic [N-1:0]   v;
      logic [N*8-1:0] pv;
      v  = '0;
      pv = '0;
      for (int i = 0; i < N; i++) begin
        if (act_mask[i]) begin
          v[i]         = bit_at(i, lane_pos[i]);
          pv[i*8 +: 8] = 8'(lane_pos[i]);
          lane_pos[i]  = (lane_pos[i] + 1) % flen(i);
        end
      end
      exp_q.push_back(v);
      pos_q.push_back(pv);
    end
  endtask

  task automatic hold_reset(int bits);
    @(negedge clk);
    #1;
    rst_n = 1'b0;
    exp_q.delete();
    pos_q.delete();
    for (int i = 0; i < N; i++) lane_pos[i] = 0;
    push_bits(bits);
    repeat (3) @(negedge clk);
    #1;
    rst_n = 1'b1;
  endtask

  task automatic drain(int keep);
    while (exp_q.size() > keep) @(negedge clk);
  endtask

  // monitor: tracks bit boundaries from R1..R3 and compares the pins
  always @(negedge clk) begin
    if (!finished) begin
      if (!rst_n) begin
        sync_cnt  = 0;
        cnt_m     = 0;
        cur_exp   = '0;
        seen_tick = 1'b0;
        prev_pins = '0;
        check(pins == '0, "R1", pins, '0);
      end else if (sync_cnt < 2) begin
        sync_cnt++;
        check(pins == '0, "R1", pins, '0);
      end else begin
        tick_m = (cnt_m >= int'(div_val));
        cnt_m  = tick_m ? 0 : cnt_m + 1;
        if (tick_m) begin
          if (exp_q.size() == 0) begin
            checks++;
            fails++;
            $display("FAIL R2 [%s] expected queue empty got=%b exp=none", ctx, pins);
          end else begin
            cur_exp = exp_q.pop_front();
            cur_pos = pos_q.pop_front();
            checks++;
            if (pins != cur_exp) begin
              fails++;
              for (int i = 0; i < N; i++) begin
                if (pins[i] != cur_exp[i])
                  $display("FAIL %s [%s] lane %0d pos %0d got=%b exp=%b at %0t",
                           tag_of(i, int'(cur_pos[i*8 +: 8])), ctx, i,
                           int'(cur_pos[i*8 +: 8]), pins[i], cur_exp[i], $time);
              end
            end
          end
          if (!seen_tick) begin
            check(pins == act_mask, "R4", pins, act_mask);
            seen_tick = 1'b1;
          end
          check((prev_pins & pins) == '0, "R10", pins, prev_pins & ~pins);
          prev_pins = pins;
        end else begin
          check(pins == cur_exp, seen_tick ? "R11" : "R1", pins, cur_exp);
        end
      end
    end
  end

  task automatic finish_run();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #1_500_000;
    checks++;
    fails++;
    $display("FAIL watchdog expired got=running exp=done");
    finish_run();
  end

  initial begin
    checks   = 0;
    fails    = 0;
    finished = 1'b0;
    sync_cnt = 0;
    cnt_m    = 0;
    for (int i = 0; i < N; i++) act_mask[i] = (row_of(i) != 0) && (col_of(i) != 0);
    rst_n   = 1'b0;
    div_val = DW'(2);
    ctx     = "R2 div=2 two frames";

    // R1, R4, R5..R9: two full frames of the longest lane at three clocks per bit
    hold_reset(470);
    drain(20);

    // R3: lengthen the bit, then shrink it below the running count
    push_bits(200);
    ctx = "R3 grow to 5";
    @(negedge clk);
    #1;
    div_val = DW'(5);
    do begin
      @(negedge clk);
      #1;
    end while (cnt_m != 4);
    ctx = "R3 shrink past count";
    div_val = DW'(1);
    repeat (30) @(negedge clk);
    // R2: a setting of 0 gives one bit per clock
    #1;
    ctx = "R2 div=0";
    div_val = '0;
    drain(20);

    // reset in the middle of the 31/31 lane's column burst, then restart aligned
    push_bits(150);
    drain(20);
    ctx = "R4 restart after mid-frame reset";
    hold_reset(450);
    drain(20);

    finish_run();
  end

endmodule